// File: doc/BRIEF.md
# Programmable Memory-Cycle Microsequencer

This block produces the control-signal waveforms for an external memory device by stepping through words held in an internal array, one word per clock. Every array word carries the control levels for one cycle, a flag that requests a data acknowledge to the host, and a flag that marks the final word of a pattern. A small mode register picks what the next host access does: run a stored access pattern, write one array word from the staging data register, read one array word into that register, or launch a pattern chosen by software. The same host transaction does all four jobs. Only the mode register decides which one happens.

The host side presents accesses on a valid/ready request channel. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While the block is busy the host must hold `req_valid` and `req_write` steady and wait. Completion (`done`, `done_err`) and data acknowledges (`ack`) are single-cycle pulses with no back-pressure. A timeout input, `exc_in`, abandons a running pattern and switches to a fixed shutdown pattern. When that shutdown pattern ends, the block reports an error completion.

Top module: `useq_top`

## Requirements
- R1: After reset the following hold: `mode_q` = 0, `data_q` = 0, `busy` = 0, `req_ready` = 1, `mem_ctl` = 0, and `ack`, `done` and `done_err` are low.
- R2: `req_ready` equals the inverse of `busy`. A request held high while busy is not taken. `done` is followed by an idle cycle in which a new request can be taken.
- R3: Host register writes behave as follows:
  - `cfg_wr` with `cfg_sel`=0 loads `mode_q` from `cfg_wdata[7:0]`. Bits [7:6] are the operation (00 normal, 01 load array, 10 read array, 11 software run) and bits [5:0] are the array address.
  - `cfg_sel`=1 loads `data_q` from `cfg_wdata`.
  - A write is ignored while `busy` is high, and also in a cycle where a request is taken.
- R4: With operation 01, a write request stores `data_q` into the array at the address field. `done` is high in the cycle after acceptance. From the following cycle the address field is one higher, wrapping from 63 to 0.
- R5: With operation 10, a read request copies the array word at the address field into `data_q`. `done` is high in the cycle after acceptance. From the following cycle the new data and the incremented address field are visible.
- R6: Array word layout: bit 31 marks the last word, bit 30 requests an acknowledge, and bits [15:0] are the control levels. With operation 00:
  - A read request executes words from address 0 and a write request executes words from address 8, whatever the address field holds.
  - Words execute one per cycle, starting the cycle after acceptance, with `mem_ctl` showing bits [15:0].
  - `ack` is high for each word whose bit 30 is set.
  - `done` is high in the cycle of the word whose bit 31 is set.
- R7: With operation 11, a write request executes words from the address field onward. `ack` never rises, `done` marks the last word, and the mode register is left unchanged.
- R8: These combinations take effect on nothing: operation 11 with a read, operation 01 with a read, and operation 10 with a write. Each completes with `done` in the cycle after acceptance and changes neither register nor any array word.
- R9: If `exc_in` is high during an executing pattern word:
  - That word produces neither `ack` nor `done`, even if it is the last word.
  - From the next cycle, words execute from address 60 with no acknowledges.
  - The last word of that pattern raises `done` together with `done_err`.
- R10: `exc_in` has no effect while idle, during an array access, or while the shutdown pattern runs.
- R11: `mem_ctl` is 0 in every cycle in which no pattern word is executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Host register write strobe |
| cfg_sel | input | 1 | Register select: 0 mode, 1 data |
| cfg_wdata | input | 32 | Register write value |
| mode_q | output | 8 | Mode register: operation [7:6], address [5:0] |
| data_q | output | 32 | Staging data register |
| busy | output | 1 | Sequencer is executing or accessing the array |
| req_valid | input | 1 | Host access request valid |
| req_write | input | 1 | Request direction: 1 write, 0 read |
| req_ready | output | 1 | Request can be taken this cycle |
| ack | output | 1 | Data acknowledge from an executed word |
| done | output | 1 | Access or pattern completion pulse |
| done_err | output | 1 | Completion was via the shutdown pattern |
| exc_in | input | 1 | Timeout exception request |
| mem_ctl | output | 16 | Memory control levels |

## Verification
Two collisions matter here. The first is the timeout arriving in the same cycle as an ordinary pattern word, including the word that ends the pattern. The timeout is raised at every step position of a four-word pattern, in both host-launched and software-launched runs. The judgement is that the colliding word shows its control levels but gives neither acknowledge nor completion, and that the trace then continues at address 60. The second is a host register write landing in the cycle where a request is taken; there the staging value must stay as it was, and the array word written must be the older value.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    OP_NORMAL = 2'b00,
    OP_LOAD   = 2'b01,
    OP_DUMP   = 2'b10,
    OP_RUN    = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_EXC,
    ST_ACC
  } state_e;

  typedef enum logic [1:0] {
    AK_NONE,
    AK_LOAD,
    AK_DUMP
  } acc_e;

endpackage

// File: rtl/useq_ram.sv
module useq_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, registered read; read-during-write returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/useq_regs.sv
module useq_regs
  import useq_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          accept,
  input  logic          mad_inc,
  input  logic          data_load,
  input  logic [DW-1:0] load_word,
  output op_e           op,
  output logic [AW-1:0] mad,
  output logic [DW-1:0] data_q
);
  logic blocked;
  assign blocked = busy | accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op  <= OP_NORMAL;
      mad <= '0;
    end else if (mad_inc) begin
      mad <= mad + 1'b1;
    end else if (cfg_wr && !cfg_sel && !blocked) begin
      op  <= op_e'(cfg_wdata[AW+1:AW]);
      mad <= cfg_wdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            data_q <= '0;
    else if (data_load)                    data_q <= load_word;
    else if (cfg_wr && cfg_sel && !blocked) data_q <= cfg_wdata;
  end

  // R3: host writes cannot touch the mode while the sequencer is busy
  assert_cfg_ignored_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mad_inc) |=> $stable({op, mad}));

  // R4: address field advances by one, wrapping at the top
  assert_mad_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mad_inc |=> (mad == $past(mad) + 1'b1));
endmodule

// File: rtl/useq_engine.sv
module useq_engine
  import useq_pkg::*;
#(
  parameter int AW       = 6,
  parameter int CTL_W    = 16,
  parameter int RD_BASE  = 0,
  parameter int WR_BASE  = 8,
  parameter int EXC_BASE = 60,
  parameter logic [CTL_W-1:0] IDLE_CTL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  op_e              op,
  input  logic [AW-1:0]    mad,
  input  logic             exc_in,
  input  logic             word_last,
  input  logic             word_ta,
  input  logic [CTL_W-1:0] word_ctl,
  output logic             req_ready,
  output logic             busy,
  output logic             accept,
  output logic [AW-1:0]    ram_addr,
  output logic             ram_we,
  output logic             mad_inc,
  output logic             data_load,
  output logic             ack,
  output logic             done,
  output logic             done_err,
  output logic [CTL_W-1:0] mem_ctl
);
  localparam logic [AW-1:0] RD_START  = AW'(RD_BASE);
  localparam logic [AW-1:0] WR_START  = AW'(WR_BASE);
  localparam logic [AW-1:0] EXC_START = AW'(EXC_BASE);

  state_e        state, state_nxt;
  logic [AW-1:0] pc, pc_nxt;
  logic          sw, sw_nxt;
  acc_e          kind, kind_nxt;

  assign busy      = (state != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign mem_ctl   = (state == ST_RUN || state == ST_EXC) ? word_ctl : IDLE_CTL;

  always_comb begin
    state_nxt = state;
    pc_nxt    = pc;
    sw_nxt    = sw;
    kind_nxt  = kind;
    ram_addr  = pc + 1'b1;
    ram_we    = 1'b0;
    mad_inc   = 1'b0;
    data_load = 1'b0;
    ack       = 1'b0;
    done      = 1'b0;
    done_err  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          state_nxt = ST_ACC;
          kind_nxt  = AK_NONE;
          case (op)
            OP_NORMAL: begin
              state_nxt = ST_RUN;
              sw_nxt    = 1'b0;
              pc_nxt    = req_write ? WR_START : RD_START;
              ram_addr  = pc_nxt;
            end
            OP_RUN: if (req_write) begin
              state_nxt = ST_RUN;
              sw_nxt    = 1'b1;
              pc_nxt    = mad;
              ram_addr  = mad;
            end
            OP_LOAD: if (req_write) begin
              kind_nxt = AK_LOAD;
              ram_we   = 1'b1;
              ram_addr = mad;
            end
            OP_DUMP: if (!req_write) begin
              kind_nxt = AK_DUMP;
              ram_addr = mad;
            end
          endcase
        end
      end
      ST_RUN: begin
        if (exc_in) begin
          state_nxt = ST_EXC;
          pc_nxt    = EXC_START;
          ram_addr  = EXC_START;
        end else begin
          ack = word_ta && !sw;
          if (word_last) begin
            done      = 1'b1;
            state_nxt = ST_IDLE;
          end else begin
            pc_nxt = pc + 1'b1;
          end
        end
      end
      ST_EXC: begin
        if (word_last) begin
          done      = 1'b1;
          done_err  = 1'b1;
          state_nxt = ST_IDLE;
        end else begin
          pc_nxt = pc + 1'b1;
        end
      end
      ST_ACC: begin
        done      = 1'b1;
        mad_inc   = (kind != AK_NONE);
        data_load = (kind == AK_DUMP);
        state_nxt = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
      sw    <= 1'b0;
      kind  <= AK_NONE;
    end else begin
      state <= state_nxt;
      pc    <= pc_nxt;
      sw    <= sw_nxt;
      kind  <= kind_nxt;
    end
  end

  // R2: every completion hands control back to idle
  assert_done_then_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R9: a timeout during a pattern word redirects to the shutdown pattern
  assert_exc_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && exc_in) |=> (state == ST_EXC && pc == EXC_START));

  // R7: a software run starts at the address field
  assert_sw_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_RUN && req_write) |=> (state == ST_RUN && pc == $past(mad)));

  // R4: a load access completes one cycle later and advances the address
  assert_load_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_LOAD && req_write) |=> (done && mad_inc));
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DW       = 32,
  parameter int CTL_W    = 16,
  parameter int RD_BASE  = 0,
  parameter int WR_BASE  = 8,
  parameter int EXC_BASE = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [AW+1:0]    mode_q,
  output logic [DW-1:0]    data_q,
  output logic             busy,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  output logic             ack,
  output logic             done,
  output logic             done_err,
  input  logic             exc_in,
  output logic [CTL_W-1:0] mem_ctl
);
  localparam int LAST_BIT = DW - 1;
  localparam int TA_BIT   = DW - 2;

  op_e           op;
  logic [AW-1:0] mad;
  logic [AW-1:0] ram_addr;
  logic          ram_we;
  logic [DW-1:0] rdata;
  logic          accept;
  logic          mad_inc;
  logic          data_load;

  assign mode_q = {op, mad};

  useq_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .busy      (busy),
    .accept    (accept),
    .mad_inc   (mad_inc),
    .data_load (data_load),
    .load_word (rdata),
    .op        (op),
    .mad       (mad),
    .data_q    (data_q)
  );

  useq_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .addr  (ram_addr),
    .we    (ram_we),
    .wdata (data_q),
    .rdata (rdata)
  );

  useq_engine #(
    .AW(AW), .CTL_W(CTL_W), .RD_BASE(RD_BASE), .WR_BASE(WR_BASE),
    .EXC_BASE(EXC_BASE), .IDLE_CTL('0)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .op        (op),
    .mad       (mad),
    .exc_in    (exc_in),
    .word_last (rdata[LAST_BIT]),
    .word_ta   (rdata[TA_BIT]),
    .word_ctl  (rdata[CTL_W-1:0]),
    .req_ready (req_ready),
    .busy      (busy),
    .accept    (accept),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .mad_inc   (mad_inc),
    .data_load (data_load),
    .ack       (ack),
    .done      (done),
    .done_err  (done_err),
    .mem_ctl   (mem_ctl)
  );
endmodule

// File: tb/useq_top_tb.sv
module useq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  mode_q;
  logic [31:0] data_q;
  logic        busy, req_valid = 0, req_write = 0, req_ready;
  logic        ack, done, done_err, exc_in = 0;
  logic [15:0] mem_ctl;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mode_q(mode_q), .data_q(data_q), .busy(busy),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .ack(ack), .done(done), .done_err(done_err), .exc_in(exc_in),
    .mem_ctl(mem_ctl)
  );

  // stored pattern: last every fourth word, ack unless index divisible by 3
  function automatic logic [31:0] word_of(int i);
    logic [31:0] w;
    w[31]    = (i % 4 == 3);
    w[30]    = (i % 3 != 0);
    w[29:16] = 14'(i * 7 + 3);
    w[15:0]  = 16'(i * 291) ^ 16'hA5C3;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic cfg(input bit sel, input logic [31:0] v);
    cfg_wr = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic access(input bit wr, input string tag);
    req_valid = 1; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    #1;
    chk({tag, " completion"}, {61'd0, done, done_err, ack}, 64'b100);
    @(negedge clk);
  endtask

  task automatic run_check(input bit wr, input int start, input bit sw,
                           input int exc_at, input bit hold, input string tag);
    int a;
    bit in_exc;
    bit fin;
    a = start; in_exc = 0; fin = 0;
    chk({tag, " ready before"}, {63'd0, req_ready}, 64'd1);
    req_valid = 1; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    for (int s = 0; s < 24 && !fin; s++) begin
      logic [31:0] w;
      logic eack, edone, eerr;
      w = word_of(a);
      exc_in = in_exc ? hold : (s == exc_at);
      #1;
      eack  = !in_exc && !exc_in && !sw && w[30];
      edone = (in_exc || !exc_in) && w[31];
      eerr  = in_exc && w[31];
      chk(tag, {45'd0, mem_ctl, ack, done, done_err}, {45'd0, w[15:0], eack, edone, eerr});
      if (!in_exc && exc_in) begin a = 60; in_exc = 1; end
      else if (w[31]) fin = 1;
      else a = (a + 1) % 64;
      @(negedge clk);
      exc_in = 0;
    end
    #1;
    chk({tag, " ended idle"}, {62'd0, fin, busy}, 64'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state, R11 idle control levels
    chk("R1 reset regs", {24'd0, mode_q, data_q}, 64'd0);
    chk("R1 reset flags", {59'd0, busy, req_ready, ack, done, done_err}, 64'b01000);
    chk("R11 idle mem_ctl", {48'd0, mem_ctl}, 64'd0);
    @(negedge clk);

    // R3 exhaustive mode register sweep, then data register
    for (int v = 0; v < 256; v++) begin
      cfg(0, 32'(v) | 32'hFFFF_FF00);
      chk("R3 mode write", {56'd0, mode_q}, 64'(v));
    end
    cfg(1, 32'hCAFE_0123);
    chk("R3 data write", {32'd0, data_q}, 64'hCAFE_0123);

    // R4 load every array word with auto-advancing address
    cfg(0, 32'h40);
    for (int i = 0; i < 64; i++) begin
      cfg(1, word_of(i));
      access(1, "R4 load");
      chk("R4 addr advance", {56'd0, mode_q}, {56'd0, 2'b01, 6'((i + 1) % 64)});
    end

    // R5 read every word back
    cfg(0, 32'h80);
    for (int i = 0; i < 64; i++) begin
      access(0, "R5 dump");
      chk("R5 data", {32'd0, data_q}, {32'd0, word_of(i)});
      chk("R5 addr advance", {56'd0, mode_q}, {56'd0, 2'b10, 6'((i + 1) % 64)});
    end

    // R6 normal accesses, address field irrelevant
    cfg(0, 32'h00);
    run_check(0, 0, 0, 99, 0, "R6 read pattern");
    run_check(1, 8, 0, 99, 0, "R6 write pattern");
    cfg(0, 32'h25);
    run_check(0, 0, 0, 99, 0, "R6 read other addr");
    run_check(1, 8, 0, 99, 0, "R6 write other addr");
    #1 chk("R11 after pattern", {48'd0, mem_ctl}, 64'd0);

    // R7 software run from every start address
    for (int a = 0; a < 64; a++) begin
      cfg(0, 32'hC0 | 32'(a));
      run_check(1, a, 1, 99, 0, "R7 sw run");
      chk("R7 mode kept", {56'd0, mode_q}, 64'(32'hC0 | a));
    end

    // R9 timeout at every step, host and software runs
    for (int k = 0; k < 4; k++) begin
      cfg(0, 32'h00);
      run_check(0, 0, 0, k, 0, "R9 exc normal");
      cfg(0, 32'hC0 | 32'd20);
      run_check(1, 20, 1, k, 0, "R9 exc sw");
    end
    // R10 timeout held through the shutdown pattern
    cfg(0, 32'h00);
    run_check(1, 8, 0, 1, 1, "R10 exc held");

    // R8 mismatched operation and direction
    begin
      logic [7:0] ops [3];
      bit         dirs [3];
      ops[0] = 8'hC0 | 8'd33; dirs[0] = 0;
      ops[1] = 8'h40 | 8'd33; dirs[1] = 0;
      ops[2] = 8'h80 | 8'd33; dirs[2] = 1;
      for (int c = 0; c < 3; c++) begin
        cfg(0, 32'(ops[c]));
        cfg(1, 32'h0BAD_F00D);
        access(dirs[c], "R8 no effect");
        chk("R8 mode kept", {56'd0, mode_q}, {56'd0, ops[c]});
        chk("R8 data kept", {32'd0, data_q}, 64'h0BAD_F00D);
      end
      cfg(0, 32'h80 | 32'd33);
      access(0, "R8 readback");
      chk("R8 array word kept", {32'd0, data_q}, {32'd0, word_of(33)});
    end

    // R3 write while busy is ignored
    cfg(0, 32'hC0 | 32'd16);
    req_valid = 1; req_write = 1;
    @(negedge clk);
    req_valid = 0;
    cfg(0, 32'hFF);
    for (int t = 0; t < 10 && busy; t++) @(negedge clk);
    chk("R3 busy write ignored", {56'd0, mode_q}, 64'hD0);

    // R2 request held during busy is not taken
    cfg(0, 32'hC0);
    req_valid = 1; req_write = 1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      #1;
      chk("R2 not ready while busy", {62'd0, req_ready, busy}, 64'b01);
      if (s == 3) req_valid = 0;
      @(negedge clk);
    end
    #1 chk("R2 idle after done", {62'd0, req_ready, busy}, 64'b10);

    // R10 timeout while idle and during an array access
    exc_in = 1;
    repeat (3) @(negedge clk);
    #1 chk("R10 idle exc", {46'd0, busy, done, mem_ctl}, 64'd0);
    cfg(0, 32'h40 | 32'd50);
    cfg(1, word_of(50));
    access(1, "R10 exc during access");
    exc_in = 0;
    chk("R10 addr advanced", {56'd0, mode_q}, {56'd0, 8'h40 | 8'd51});

    // R3 register write colliding with request acceptance
    cfg(0, 32'h40 | 32'd5);
    cfg(1, 32'h1234_5678);
    req_valid = 1; req_write = 1;
    cfg_wr = 1; cfg_sel = 1; cfg_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 0; cfg_wr = 0;
    @(negedge clk);
    chk("R3 collide data kept", {32'd0, data_q}, 64'h1234_5678);
    chk("R3 collide addr", {56'd0, mode_q}, 64'h46);
    cfg(0, 32'h80 | 32'd5);
    access(0, "R3 collide readback");
    chk("R3 collide stored", {32'd0, data_q}, 64'h1234_5678);

    finished = 1;
    summary();
    $finish;
  end
endmodule